// File: doc/BRIEF.md
# Vectored Interrupt Request and In-Service Tracker

This block keeps the interrupt state of one processor. It holds two 256-entry bitmaps: one for vectors that have been requested and not yet taken, and one for vectors the processor is now servicing. Each bitmap is stored as eight 32-bit words. A scan finds the highest set vector of each bitmap on every cycle. Beside the bitmaps, four special classes (system-management, non-maskable, init and external) each have their own pending flag and 8-bit vector. These classes bypass the in-service ordering.

Requests arrive as single-cycle strobes that carry a vector, a delivery mode and a level. From the current state the block picks the one interrupt to offer the processor, then registers it onto `int_pending` and `int_vector`. An `ack` pulse takes the offered interrupt. For a fixed vector, the acknowledge moves the bit from the request bitmap to the in-service bitmap. For a special class, it clears that class's flag. An `eoi` pulse retires the highest in-service vector.

Top module: `irq_vec_tracker`

## Requirements
- R1: After reset, both bitmaps are empty and no special class is pending. Every output reads zero.
- R2: A request with mode 0 (fixed) and level 1 sets bit v of the request bitmap. This bit is bit v[4:0] of word v[7:5]. `irr_top` reports the highest set vector, found by scanning the words from the top down, and `irr_any` shows that the bitmap is non-empty.
- R3: A fixed-mode request with level 0 clears that vector's request bit and leaves all other bits unchanged.
- R4: A fixed vector is offered only when the highest requested vector is strictly above the highest in-service vector, or when the in-service bitmap is empty. All outputs are registered, so they reflect a request two clock edges after the strobe.
- R5: An acknowledge of an offered fixed vector clears its request bit and sets its in-service bit on the same edge.
- R6: `eoi` clears only the highest set in-service bit.
- R7: Requests with mode 2 (system-management), 4 (non-maskable), 5 (init) and 7 (external) set that class's flag and store the vector, whatever the level. Modes 1, 3 and 6 are ignored.
- R8: `unmask_pending` is high while a system-management, non-maskable or init request is pending. A pending external request alone leaves it low.
- R9: The priority order is system-management, then non-maskable, then init, then external, and then fixed vectors. Acknowledging a special class clears only that class's flag and leaves both bitmaps unchanged.
- R10: An `ack` while `int_pending` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Vector of the request |
| req_mode | input | 3 | Delivery mode of the request |
| req_level | input | 1 | 1 asserts a fixed request, 0 withdraws it |
| ack | input | 1 | Processor takes the offered interrupt |
| eoi | input | 1 | End of interrupt for the highest in-service vector |
| int_pending | output | 1 | An interrupt is offered |
| int_vector | output | 8 | Vector of the offered interrupt |
| unmask_pending | output | 1 | System-management, non-maskable or init pending |
| irr_any | output | 1 | Request bitmap non-empty |
| irr_top | output | 8 | Highest requested vector |
| isr_any | output | 1 | In-service bitmap non-empty |
| isr_top | output | 8 | Highest in-service vector |

## Verification
Some rules are checked by assertions on every cycle. A set or clear strobe must reach the addressed bitmap bit on the next edge, and the scan result must always point at a set bit. An offered fixed vector must lie strictly above the in-service top. A pending system-management request must win, a lone external request must not raise the summary flag, and an acknowledged class flag must drop. Other behaviours only the bench scenarios can show. These are the exact vector chosen for every one of the 256 vectors and for many vector pairs, the unwinding order of nested in-service vectors through successive `eoi` pulses, the full priority cascade as each class is acknowledged, and the lack of any effect from ignored modes and from a stray acknowledge.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  typedef enum logic [2:0] {
    MODE_FIXED  = 3'd0,
    MODE_LOWPRI = 3'd1,
    MODE_SMI    = 3'd2,
    MODE_RSVD3  = 3'd3,
    MODE_NMI    = 3'd4,
    MODE_INIT   = 3'd5,
    MODE_RSVD6  = 3'd6,
    MODE_EXT    = 3'd7
  } dmode_e;

  // class index doubles as priority: lower wins
  typedef enum logic [2:0] {
    CLS_SMI   = 3'd0,
    CLS_NMI   = 3'd1,
    CLS_INIT  = 3'd2,
    CLS_EXT   = 3'd3,
    CLS_FIXED = 3'd4,
    CLS_NONE  = 3'd5
  } cls_e;

  localparam int NUM_SPECIAL = 4;
endpackage

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 32,
  parameter int VEC_W     = 8
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
  output logic                             any_o,
  output logic [VEC_W-1:0]                 top_o
);
  // Ascending scan with last-hit-wins equals a top-down first-hit search:
  // highest non-empty word, then its most significant set bit.
  always_comb begin
    any_o = 1'b0;
    top_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (|words[w]) begin
        any_o = 1'b1;
        for (int b = 0; b < WORD_W; b++) begin
          if (words[w][b]) top_o = VEC_W'(w * WORD_W + b);
        end
      end
    end
  end
endmodule

// File: rtl/irq_bitmap.sv
module irq_bitmap #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W     = $clog2(NUM_VEC),
  localparam int BIT_W     = $clog2(WORD_W),
  localparam int NUM_WORDS = NUM_VEC / WORD_W,
  localparam int WIDX_W    = VEC_W - BIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             clr_en,
  input  logic [VEC_W-1:0] clr_vec,
  output logic             any_o,
  output logic [VEC_W-1:0] top_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] words, set_m, clr_m;
  logic [NUM_VEC-1:0] flat;

  assign flat = words;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      set_m[w] = '0;
      clr_m[w] = '0;
      if (set_en && set_vec[VEC_W-1:BIT_W] == WIDX_W'(w))
        set_m[w] = WORD_W'(1) << set_vec[BIT_W-1:0];
      if (clr_en && clr_vec[VEC_W-1:BIT_W] == WIDX_W'(w))
        clr_m[w] = WORD_W'(1) << clr_vec[BIT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) words <= '0;
    else     words <= (words & ~clr_m) | set_m;
  end

  irq_msb_find #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_find (
    .words(words),
    .any_o(any_o),
    .top_o(top_o)
  );

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    set_en && !(clr_en && clr_vec == set_vec) |=> flat[$past(set_vec)]);
  // R3
  clr_lands_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en && !(set_en && set_vec == clr_vec) |=> !flat[$past(clr_vec)]);
  // R2
  top_is_set_chk: assert property (@(posedge clk) disable iff (rst)
    any_o |-> flat[top_o]);
endmodule

// File: rtl/irq_special.sv
module irq_special
  import irq_trk_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [2:0]             req_mode,
  input  logic [VEC_W-1:0]       req_vector,
  input  logic                   ack_en,
  input  logic [1:0]             ack_cls,
  output logic [NUM_SPECIAL-1:0] flags,
  output logic                   sel_valid,
  output logic [2:0]             sel_cls,
  output logic [VEC_W-1:0]       sel_vec,
  output logic                   summary
);
  logic [NUM_SPECIAL-1:0]            req_hit;
  logic [NUM_SPECIAL-1:0][VEC_W-1:0] vecs;

  always_comb begin
    req_hit = '0;
    if (req_valid) begin
      case (dmode_e'(req_mode))
        MODE_SMI:  req_hit[CLS_SMI]  = 1'b1;
        MODE_NMI:  req_hit[CLS_NMI]  = 1'b1;
        MODE_INIT: req_hit[CLS_INIT] = 1'b1;
        MODE_EXT:  req_hit[CLS_EXT]  = 1'b1;
        default:   req_hit = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      vecs  <= '0;
    end else begin
      for (int k = 0; k < NUM_SPECIAL; k++) begin
        if (req_hit[k]) begin
          flags[k] <= 1'b1;
          vecs[k]  <= req_vector;
        end else if (ack_en && ack_cls == 2'(k)) begin
          flags[k] <= 1'b0;
        end
      end
    end
  end

  // descending loop, last hit wins: lowest index has top priority
  always_comb begin
    sel_valid = 1'b0;
    sel_cls   = CLS_NONE;
    sel_vec   = '0;
    for (int k = NUM_SPECIAL - 1; k >= 0; k--) begin
      if (flags[k]) begin
        sel_valid = 1'b1;
        sel_cls   = 3'(k);
        sel_vec   = vecs[k];
      end
    end
  end

  assign summary = flags[CLS_SMI] | flags[CLS_NMI] | flags[CLS_INIT];

  // R9
  ack_drops_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ack_en && !req_hit[ack_cls] |=> !flags[$past(ack_cls)]);
endmodule

// File: rtl/irq_vec_tracker.sv
module irq_vec_tracker
  import irq_trk_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vector,
  input  logic [2:0]       req_mode,
  input  logic             req_level,
  input  logic             ack,
  input  logic             eoi,
  output logic             int_pending,
  output logic [VEC_W-1:0] int_vector,
  output logic             unmask_pending,
  output logic             irr_any,
  output logic [VEC_W-1:0] irr_top,
  output logic             isr_any,
  output logic [VEC_W-1:0] isr_top
);
  logic             req_fixed, ack_fix, ack_sp;
  logic             irr_set, irr_clr, isr_clr;
  logic [VEC_W-1:0] irr_clr_vec;
  logic             irr_any_c, isr_any_c;
  logic [VEC_W-1:0] irr_top_c, isr_top_c;
  logic [NUM_SPECIAL-1:0] sp_flags;
  logic             sp_valid, sp_summary;
  logic [2:0]       sp_cls;
  logic [VEC_W-1:0] sp_vec;
  logic             nxt_pend;
  logic [2:0]       nxt_cls, cls_q;
  logic [VEC_W-1:0] nxt_vec;

  assign req_fixed   = req_valid && (req_mode == MODE_FIXED);
  assign ack_fix     = ack && int_pending && (cls_q == CLS_FIXED);
  assign ack_sp      = ack && int_pending && (cls_q != CLS_FIXED);
  assign irr_set     = req_fixed && req_level;
  // acknowledge takes the single clear port over a withdraw
  assign irr_clr     = ack_fix || (req_fixed && !req_level);
  assign irr_clr_vec = ack_fix ? int_vector : req_vector;
  assign isr_clr     = eoi && isr_any_c;

  irq_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_irr (
    .clk(clk), .rst(rst),
    .set_en(irr_set), .set_vec(req_vector),
    .clr_en(irr_clr), .clr_vec(irr_clr_vec),
    .any_o(irr_any_c), .top_o(irr_top_c)
  );

  irq_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr (
    .clk(clk), .rst(rst),
    .set_en(ack_fix), .set_vec(int_vector),
    .clr_en(isr_clr), .clr_vec(isr_top_c),
    .any_o(isr_any_c), .top_o(isr_top_c)
  );

  irq_special #(.VEC_W(VEC_W)) u_special (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_mode(req_mode), .req_vector(req_vector),
    .ack_en(ack_sp), .ack_cls(cls_q[1:0]),
    .flags(sp_flags), .sel_valid(sp_valid), .sel_cls(sp_cls),
    .sel_vec(sp_vec), .summary(sp_summary)
  );

  always_comb begin
    nxt_pend = 1'b0;
    nxt_cls  = CLS_NONE;
    nxt_vec  = '0;
    if (sp_valid) begin
      nxt_pend = 1'b1;
      nxt_cls  = sp_cls;
      nxt_vec  = sp_vec;
    end else if (irr_any_c && (!isr_any_c || irr_top_c > isr_top_c)) begin
      nxt_pend = 1'b1;
      nxt_cls  = CLS_FIXED;
      nxt_vec  = irr_top_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_pending    <= 1'b0;
      int_vector     <= '0;
      cls_q          <= CLS_NONE;
      unmask_pending <= 1'b0;
      irr_any        <= 1'b0;
      irr_top        <= '0;
      isr_any        <= 1'b0;
      isr_top        <= '0;
    end else begin
      int_pending    <= nxt_pend;
      int_vector     <= nxt_vec;
      cls_q          <= nxt_cls;
      unmask_pending <= sp_summary;
      irr_any        <= irr_any_c;
      irr_top        <= irr_top_c;
      isr_any        <= isr_any_c;
      isr_top        <= isr_top_c;
    end
  end

  // R4
  fixed_above_isr_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && int_pending && cls_q == CLS_FIXED
      |-> !$past(isr_any_c) || (int_vector > $past(isr_top_c)));
  // R9
  smi_wins_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(sp_flags[CLS_SMI]) |-> int_pending && cls_q == CLS_SMI);
  // R8
  ext_not_summary_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(sp_flags) == 4'b1000 |-> !unmask_pending);
endmodule

// File: tb/irq_vec_tracker_tb.sv
`timescale 1ns/1ps
module irq_vec_tracker_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [7:0] req_vector = '0;
  logic [2:0] req_mode = '0;
  logic       req_level = 1'b0;
  logic       ack = 1'b0;
  logic       eoi = 1'b0;
  logic       int_pending, unmask_pending, irr_any, isr_any;
  logic [7:0] int_vector, irr_top, isr_top;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_vec_tracker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vector(req_vector),
    .req_mode(req_mode), .req_level(req_level), .ack(ack), .eoi(eoi),
    .int_pending(int_pending), .int_vector(int_vector),
    .unmask_pending(unmask_pending), .irr_any(irr_any), .irr_top(irr_top),
    .isr_any(isr_any), .isr_top(isr_top)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one-cycle strobe, then wait until the registered outputs have settled
  task automatic drive(input logic rv, input int v, input int m, input logic lv,
                       input logic a, input logic e);
    @(negedge clk);
    req_valid = rv; req_vector = 8'(v); req_mode = 3'(m); req_level = lv;
    ack = a; eoi = e;
    @(negedge clk);
    req_valid = 1'b0; ack = 1'b0; eoi = 1'b0;
    @(negedge clk);
  endtask

  task automatic req(input int v, input int m, input logic lv);
    drive(1'b1, v, m, lv, 1'b0, 1'b0);
  endtask
  task automatic do_ack(); drive(1'b0, 0, 0, 1'b0, 1'b1, 1'b0); endtask
  task automatic do_eoi(); drive(1'b0, 0, 0, 1'b0, 1'b0, 1'b1); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_pending", int_pending, 0);
    chk("R1 int_vector", int_vector, 0);
    chk("R1 unmask", unmask_pending, 0);
    chk("R1 irr_any", irr_any, 0);
    chk("R1 isr_any", isr_any, 0);

    // sweep of every vector through request, ack, eoi
    for (int v = 0; v < 256; v++) begin
      req(v, 0, 1'b1);
      chk("R2 irr_top", irr_top, v);
      chk("R2 irr_any", irr_any, 1);
      chk("R4 offered", int_pending, 1);
      chk("R4 vector", int_vector, v);
      do_ack();
      chk("R5 irr cleared", irr_any, 0);
      chk("R5 isr_top", isr_top, v);
      chk("R5 no offer", int_pending, 0);
      do_eoi();
      chk("R6 isr empty", isr_any, 0);
    end

    // pairs: highest wins, withdraw by level 0
    for (int v = 0; v < 256; v++) begin
      int b;
      int mx;
      b = (v * 37 + 11) % 256;
      if (b != v) begin
        mx = (v > b) ? v : b;
        req(v, 0, 1'b1);
        req(b, 0, 1'b1);
        chk("R2 pair top", irr_top, mx);
        chk("R4 pair vector", int_vector, mx);
        req(v, 0, 1'b0);
        chk("R3 withdraw keeps other", irr_top, b);
        req(b, 0, 1'b0);
        chk("R3 withdraw empties", irr_any, 0);
      end
    end

    // nesting against the in-service top
    req(40, 0, 1'b1); do_ack();
    chk("R5 isr 40", isr_top, 40);
    req(40, 0, 1'b1);
    chk("R4 equal blocked", int_pending, 0);
    req(40, 0, 1'b0);
    req(30, 0, 1'b1);
    chk("R4 lower blocked", int_pending, 0);
    chk("R2 irr 30", irr_top, 30);
    // R10 stray ack
    do_ack();
    chk("R10 irr kept", irr_top, 30);
    chk("R10 isr kept", isr_top, 40);
    req(50, 0, 1'b1);
    chk("R4 higher offered", int_vector, 50);
    do_ack();
    chk("R5 isr 50", isr_top, 50);
    chk("R4 30 under 50", int_pending, 0);
    do_eoi();
    chk("R6 top retired", isr_top, 40);
    chk("R6 still blocked", int_pending, 0);
    do_eoi();
    chk("R6 isr empty", isr_any, 0);
    chk("R4 30 offered", int_vector, 30);
    do_ack(); do_eoi();
    chk("R6 all clear", isr_any + irr_any, 0);
    do_ack();
    chk("R10 idle ack", isr_any + irr_any + int_pending, 0);

    // special classes: modes 2 smi, 4 nmi, 5 init, 7 ext
    req(200, 0, 1'b1);
    req(33, 7, 1'b1);
    chk("R9 ext over fixed", int_vector, 33);
    chk("R8 ext excluded", unmask_pending, 0);
    req(5, 5, 1'b0);
    chk("R7 init any level", int_vector, 5);
    chk("R8 init summary", unmask_pending, 1);
    req(2, 4, 1'b1);
    chk("R9 nmi over init", int_vector, 2);
    req(119, 2, 1'b1);
    chk("R9 smi top", int_vector, 119);
    req(9, 3, 1'b1); req(10, 1, 1'b1); req(11, 6, 1'b1);
    chk("R7 ignored modes vec", int_vector, 119);
    chk("R7 ignored modes irr", irr_top, 200);
    do_ack();
    chk("R9 nmi next", int_vector, 2);
    do_ack();
    chk("R9 init next", int_vector, 5);
    do_ack();
    chk("R9 ext next", int_vector, 33);
    chk("R8 only ext left", unmask_pending, 0);
    chk("R9 bitmaps untouched", isr_any * 1000 + irr_top, 200);
    do_ack();
    chk("R9 fixed last", int_vector, 200);
    do_ack();
    chk("R5 isr 200", isr_top, 200);
    chk("R5 nothing left", int_pending, 0);
    do_eoi();
    chk("R6 final", isr_any, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule